// File: doc/BRIEF.md
# Host DMA Slave Memory Port

This block lets an external host reach a processor's internal program memory (24-bit words) and data memory (16-bit words) over one shared 16-bit bus. The host controls it with four signals: a select, an address-latch strobe, a write strobe and a read strobe. It watches an active-low acknowledge and issues a new operation only while that acknowledge is low. Any operation that needs the internal memories raises a request toward the internal memory arbiter. The block holds that request until the arbiter grants a cycle. The acknowledge stays high for the same span.

A program-memory word does not fit on the bus, so it moves as two bus transfers. On a write, the upper 16 bits first go into a holding register. The second write then supplies the low 8 bits, and the whole word is committed. On a read, one memory access fetches the word. The upper 16 bits are returned first, and the low 8 bits follow on the next read without a second memory access. The word address advances by itself after each completed word.

The processor can also load the address through a control write. Either kind of address load breaks an unfinished write pair. A boot input, sampled while reset is held, keeps the processor stopped until the host has written program address zero.

Top module: `hdp_port`

## Requirements
- R1: While reset is high and on the cycle after it falls, host_ack_n is low, mem_req is low, host_ad_out is zero, and the word address is 0 in program space.
- R2: An address load comes either from host_sel with host_ale, or from ctl_wr with ctl_data (ctl_wr wins and needs no select). The loaded bus word uses bit 15 to pick the space (0 = program, 1 = data) and its low ADDR_W bits as the word address.
- R3: The first write of a program-memory pair stores the bus value as the upper 16 bits in a holding register. host_ack_n stays low on the next cycle, and no memory request is raised.
- R4: The second write of a program-memory pair commits {held 16 bits, bus bits 7:0} as one 24-bit word. From the next cycle, host_ack_n and mem_req stay high until the first clock edge at which mem_gnt is high. Both are low after that edge.
- R5: A data-memory write commits the 16-bit bus value, with the same request and acknowledge behaviour as R4.
- R6: An address load (host or control) that arrives between the two halves of a program-memory write discards the held half. The next program-memory write is then a new first half.
- R7: The first read of a program-memory pair fetches the word through a granted memory cycle and then shows bits 23:8 on host_ad_out. The second read shows {8'h00, bits 7:0} on the next cycle, with no request and with host_ack_n kept low.
- R8: A data-memory read fetches through a granted memory cycle and then shows the 16-bit word on host_ad_out.
- R9: The word address increments modulo 2^ADDR_W after each data-memory transfer and after the second half of a program-memory transfer. It does not increment after a first half.
- R10: Strobes without host_sel, and strobes while host_ack_n is high, change neither memory nor the address, and raise no request.
- R11: When boot_mode is high during reset, cpu_hold is high after reset. It falls at the edge that commits a complete program-memory word to address 0, and no other write clears it. When boot_mode is low during reset, cpu_hold is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | Boot selection, sampled during reset |
| host_sel | input | 1 | Host select, qualifies the three strobes |
| host_ale | input | 1 | Host address-latch strobe |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_ad_in | input | 16 | Address or write data from the host |
| host_ad_out | output | 16 | Read data toward the host |
| host_ack_n | output | 1 | Active-low ready/acknowledge to the host |
| ctl_wr | input | 1 | Processor-side address register write |
| ctl_data | input | 16 | Value for the processor-side address write |
| mem_req | output | 1 | Request for an internal memory cycle |
| mem_gnt | input | 1 | Grant of the requested memory cycle |
| cpu_hold | output | 1 | Holds processor execution during boot |

## Verification
A corrupted pairing flag shows up at once in the traffic. A program write that should be a first half raises a request the following cycle. A low-half read comes back as a fresh fetch of the upper bits instead of the 8-bit remainder. A wrong address or a lost held half stays hidden until the affected word is read back, so the bench first fills both memories through auto-increment and then compares every later read against its own model. A stuck request or acknowledge is caught on the first cycle after the grant edge.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
    localparam int BUS_W = 16;
    localparam int PM_W  = 24;
    localparam int LO_W  = PM_W - BUS_W;

    typedef enum logic {SP_PM = 1'b0, SP_DM = 1'b1} space_e;

    typedef struct packed {
        logic            is_wr;
        space_e          sp;
        logic [PM_W-1:0] data;
    } job_t;

    function automatic space_e decode_sp(input logic [BUS_W-1:0] w);
        return w[BUS_W-1] ? SP_DM : SP_PM;
    endfunction

    function automatic logic [PM_W-1:0] pm_join(input logic [BUS_W-1:0] hi,
                                                 input logic [BUS_W-1:0] lo);
        return {hi, lo[LO_W-1:0]};
    endfunction
endpackage

// File: rtl/hdp_addr_ctl.sv
module hdp_addr_ctl
    import hdp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BUS_W-1:0]  load_val,
    input  logic              step,
    input  logic              set_half,
    input  logic              clr_half,
    output logic [ADDR_W-1:0] addr,
    output space_e            sp,
    output logic              half
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            sp   <= SP_PM;
            half <= 1'b0;
        end else if (load) begin
            addr <= ADDR_W'(load_val[BUS_W-2:0]);
            sp   <= decode_sp(load_val);
            half <= 1'b0;
        end else begin
            if (step)
                addr <= addr + 1'b1;
            if (clr_half)
                half <= 1'b0;
            else if (set_half)
                half <= 1'b1;
        end
    end
endmodule

// File: rtl/hdp_mem.sv
module hdp_mem #(
    parameter int AW = 8,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/hdp_boot.sv
module hdp_boot (
    input  logic clk,
    input  logic rst,
    input  logic boot_mode,
    input  logic zero_word_done,
    output logic cpu_hold
);
    always_ff @(posedge clk) begin
        if (rst)
            cpu_hold <= boot_mode;
        else if (zero_word_done)
            cpu_hold <= 1'b0;
    end
endmodule

// File: rtl/hdp_port.sv
module hdp_port
    import hdp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        boot_mode,
    input  logic        host_sel,
    input  logic        host_ale,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [15:0] host_ad_in,
    output logic [15:0] host_ad_out,
    output logic        host_ack_n,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_data,
    output logic        mem_req,
    input  logic        mem_gnt,
    output logic        cpu_hold
);
    localparam int PAD_W = BUS_W - LO_W;

    logic              busy;
    job_t              job;
    logic [ADDR_W-1:0] job_addr;
    logic [BUS_W-1:0]  hold_q;
    logic [PM_W-1:0]   rd_latch;
    logic [BUS_W-1:0]  ad_out_q;

    logic [ADDR_W-1:0] cur_addr;
    space_e            cur_sp;
    logic              half;

    logic              accept, ld, wr_go, rd_go, done;
    logic              pm_hi_wr, pm_lo_rd, launch, step, set_half, clr_half;
    logic [BUS_W-1:0]  ld_val;
    logic              pm_we, dm_we;
    logic [PM_W-1:0]   pm_rdata;
    logic [BUS_W-1:0]  dm_rdata;

    // decode of host traffic; the control-side load takes precedence
    assign accept   = host_sel & ~busy & ~ctl_wr;
    assign ld       = ctl_wr | (accept & host_ale);
    assign ld_val   = ctl_wr ? ctl_data : host_ad_in;
    assign wr_go    = accept & ~host_ale & host_wr;
    assign rd_go    = accept & ~host_ale & ~host_wr & host_rd;
    assign done     = busy & mem_gnt;

    assign pm_hi_wr = wr_go & (cur_sp == SP_PM) & ~half;
    assign pm_lo_rd = rd_go & (cur_sp == SP_PM) & half;
    assign launch   = (wr_go & ~pm_hi_wr) | (rd_go & ~pm_lo_rd);
    assign step     = (done & (job.is_wr | (job.sp == SP_DM))) | pm_lo_rd;
    assign set_half = pm_hi_wr | (rd_go & (cur_sp == SP_PM) & ~half);
    assign clr_half = (wr_go & (cur_sp == SP_PM) & half) | pm_lo_rd;

    assign pm_we    = done & job.is_wr & (job.sp == SP_PM);
    assign dm_we    = done & job.is_wr & (job.sp == SP_DM);

    hdp_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .step     (step),
        .set_half (set_half),
        .clr_half (clr_half),
        .addr     (cur_addr),
        .sp       (cur_sp),
        .half     (half)
    );

    hdp_mem #(.AW(ADDR_W), .W(PM_W)) u_pm (
        .clk   (clk),
        .we    (pm_we),
        .addr  (job_addr),
        .wdata (job.data),
        .rdata (pm_rdata)
    );

    hdp_mem #(.AW(ADDR_W), .W(BUS_W)) u_dm (
        .clk   (clk),
        .we    (dm_we),
        .addr  (job_addr),
        .wdata (job.data[BUS_W-1:0]),
        .rdata (dm_rdata)
    );

    hdp_boot u_boot (
        .clk            (clk),
        .rst            (rst),
        .boot_mode      (boot_mode),
        .zero_word_done (pm_we & (job_addr == '0)),
        .cpu_hold       (cpu_hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            job      <= '0;
            job_addr <= '0;
            hold_q   <= '0;
            rd_latch <= '0;
            ad_out_q <= '0;
        end else begin
            if (pm_hi_wr)
                hold_q <= host_ad_in;
            if (launch) begin
                busy      <= 1'b1;
                job.is_wr <= wr_go;
                job.sp    <= cur_sp;
                job.data  <= (cur_sp == SP_PM) ? pm_join(hold_q, host_ad_in)
                                               : {{LO_W{1'b0}}, host_ad_in};
                job_addr  <= cur_addr;
            end else if (done) begin
                busy <= 1'b0;
                if (!job.is_wr) begin
                    if (job.sp == SP_PM) begin
                        rd_latch <= pm_rdata;
                        ad_out_q <= pm_rdata[PM_W-1:LO_W];
                    end else begin
                        ad_out_q <= dm_rdata;
                    end
                end
            end
            if (pm_lo_rd)
                ad_out_q <= {{PAD_W{1'b0}}, rd_latch[LO_W-1:0]};
        end
    end

    assign host_ad_out = ad_out_q;
    assign host_ack_n  = busy;
    assign mem_req     = busy;
endmodule

// File: rtl/hdp_port_chk.sv
module hdp_port_chk
    import hdp_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   host_sel,
    input logic   host_ale,
    input logic   host_rd,
    input logic   host_wr,
    input logic   ctl_wr,
    input logic   host_ack_n,
    input logic   mem_req,
    input logic   mem_gnt,
    input logic   cpu_hold,
    input space_e cur_sp,
    input logic   half
);
    logic pm_first_wr, pm_second_rd;

    assign pm_first_wr  = host_sel && host_wr && !host_ale && !ctl_wr && !host_ack_n
                          && (cur_sp == SP_PM) && !half;
    assign pm_second_rd = host_sel && host_rd && !host_wr && !host_ale && !ctl_wr
                          && !host_ack_n && (cur_sp == SP_PM) && half;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!host_ack_n && !mem_req));

    p_first_half_r3: assert property (@(posedge clk) disable iff (rst)
        pm_first_wr |=> (!host_ack_n && !mem_req));

    p_wait_gnt_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && host_ack_n));

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=> (!mem_req && !host_ack_n));

    p_low_read_r7: assert property (@(posedge clk) disable iff (rst)
        pm_second_rd |=> (!mem_req && !host_ack_n));

    p_no_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (!host_sel && !mem_req) |=> !mem_req);

    p_boot_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        !cpu_hold |=> !cpu_hold);
endmodule

bind hdp_port hdp_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_sel   (host_sel),
    .host_ale   (host_ale),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .ctl_wr     (ctl_wr),
    .host_ack_n (host_ack_n),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .cpu_hold   (cpu_hold),
    .cur_sp     (cur_sp),
    .half       (half)
);

// File: tb/hdp_port_tb.sv
module hdp_port_tb;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_mode = 1'b0;
    logic        host_sel = 1'b0, host_ale = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [15:0] host_ad_in = '0;
    logic [15:0] host_ad_out;
    logic        host_ack_n;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_data = '0;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic        cpu_hold;

    hdp_port #(.ADDR_W(AW)) u_dut (.*);

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    logic [23:0] pm_ref [DEPTH];
    logic [15:0] dm_ref [DEPTH];
    logic [AW-1:0] r_addr;
    bit          r_dm, r_half;
    logic [15:0] r_hold;
    logic [23:0] r_word;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] lat_word(input bit dm, input logic [AW-1:0] a);
        return {dm, 7'b0, a};
    endfunction

    function automatic logic [15:0] exp_pm_hi(input logic [23:0] w);
        return w[23:8];
    endfunction

    function automatic logic [15:0] exp_pm_lo(input logic [23:0] w);
        return {8'h00, w[7:0]};
    endfunction

    task automatic strobe(input bit ale, input bit rd, input bit wr, input logic [15:0] d);
        host_sel = 1'b1; host_ale = ale; host_rd = rd; host_wr = wr; host_ad_in = d;
        @(negedge clk);
        host_sel = 1'b0; host_ale = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    endtask

    task automatic finish_busy(input int dly, input string req);
        chk(host_ack_n === 1'b1 && mem_req === 1'b1, req, {host_ack_n, mem_req}, 2'b11);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk(host_ack_n === 1'b1 && mem_req === 1'b1, req, {host_ack_n, mem_req}, 2'b11);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        chk(host_ack_n === 1'b0 && mem_req === 1'b0, req, {host_ack_n, mem_req}, 2'b00);
    endtask

    task automatic do_latch(input bit dm, input logic [AW-1:0] a, input bit via_ctl);
        if (via_ctl) begin
            ctl_wr = 1'b1; ctl_data = lat_word(dm, a);
            @(negedge clk);
            ctl_wr = 1'b0;
        end else begin
            strobe(1'b1, 1'b0, 1'b0, lat_word(dm, a));
        end
        chk(host_ack_n === 1'b0 && mem_req === 1'b0, "R2", {host_ack_n, mem_req}, 2'b00);
        r_addr = a; r_dm = dm; r_half = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] d, input int dly);
        strobe(1'b0, 1'b0, 1'b1, d);
        if (!r_dm && !r_half) begin
            chk(host_ack_n === 1'b0 && mem_req === 1'b0, "R3", {host_ack_n, mem_req}, 2'b00);
            r_hold = d; r_half = 1'b1;
        end else if (!r_dm) begin
            finish_busy(dly, "R4");
            pm_ref[r_addr] = {r_hold, d[7:0]};
            r_addr++; r_half = 1'b0;
        end else begin
            finish_busy(dly, "R5");
            dm_ref[r_addr] = d;
            r_addr++;
        end
    endtask

    task automatic do_read(input int dly);
        strobe(1'b0, 1'b1, 1'b0, 16'h0);
        if (!r_dm && !r_half) begin
            finish_busy(dly, "R7");
            r_word = pm_ref[r_addr];
            chk(host_ad_out === exp_pm_hi(r_word), "R7 high part", host_ad_out, exp_pm_hi(r_word));
            r_half = 1'b1;
        end else if (!r_dm) begin
            chk(host_ack_n === 1'b0 && mem_req === 1'b0, "R7 no request", {host_ack_n, mem_req}, 2'b00);
            chk(host_ad_out === exp_pm_lo(r_word), "R7 low part", host_ad_out, exp_pm_lo(r_word));
            r_addr++; r_half = 1'b0;
        end else begin
            finish_busy(dly, "R8");
            chk(host_ad_out === dm_ref[r_addr], "R8 data", host_ad_out, dm_ref[r_addr]);
            r_addr++;
        end
    endtask

    task automatic do_reset(input bit bm);
        rst = 1'b1; boot_mode = bm;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        r_addr = '0; r_dm = 1'b0; r_half = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        chk(host_ack_n === 1'b0 && mem_req === 1'b0, "R1 during reset", {host_ack_n, mem_req}, 2'b00);
        do_reset(1'b0);
        chk(host_ack_n === 1'b0 && mem_req === 1'b0 && host_ad_out === 16'h0,
            "R1 after reset", {host_ack_n, mem_req, host_ad_out}, 18'h0);
        chk(cpu_hold === 1'b0, "R11 no boot", cpu_hold, 1'b0);

        // R9: fill both memories by auto-increment from address 0
        do_latch(1'b0, '0, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            do_write(16'($urandom), 0);
            do_write(16'($urandom), 0);
        end
        chk(r_addr === '0, "R9 model wrap", r_addr, 0);
        do_latch(1'b1, '0, 1'b1);
        for (int i = 0; i < DEPTH; i++) do_write(16'($urandom), 0);
        do_latch(1'b0, 8'd0, 1'b0);
        for (int i = 0; i < 8; i++) do_read(1);

        // R9: data-memory wrap from the last address to 0
        do_latch(1'b1, 8'hFF, 1'b0);
        do_write(16'hA5A5, 2);
        do_write(16'h5A5A, 0);
        do_latch(1'b1, 8'hFF, 1'b0);
        do_read(0);
        do_read(0);
        chk(dm_ref[0] === 16'h5A5A, "R9 wrap target", dm_ref[0], 16'h5A5A);

        // R6: host address load between halves discards the held half
        do_latch(1'b0, 8'd10, 1'b0);
        do_write(16'h1111, 0);
        do_latch(1'b0, 8'd10, 1'b0);
        do_write(16'h2222, 0);
        do_write(16'h3333, 1);
        do_latch(1'b0, 8'd10, 1'b0);
        do_read(0);
        chk(host_ad_out === 16'h2222, "R6 host load", host_ad_out, 16'h2222);
        do_read(0);
        chk(host_ad_out === 16'h0033, "R6 host load low", host_ad_out, 16'h0033);
        // R6: control write between halves
        do_write(16'h4444, 0);
        do_latch(1'b0, 8'd20, 1'b1);
        do_write(16'h5555, 0);
        do_write(16'h6677, 0);
        do_latch(1'b0, 8'd20, 1'b0);
        do_read(2);
        chk(host_ad_out === 16'h5555, "R6 ctl load", host_ad_out, 16'h5555);

        // R10: strobes without select change nothing
        do_latch(1'b1, 8'd30, 1'b0);
        host_wr = 1'b1; host_ad_in = 16'hDEAD;
        @(negedge clk);
        host_wr = 1'b0;
        chk(host_ack_n === 1'b0 && mem_req === 1'b0, "R10 no select", {host_ack_n, mem_req}, 2'b00);
        do_read(0);
        // R10: strobe while busy is ignored
        do_latch(1'b1, 8'd40, 1'b0);
        strobe(1'b0, 1'b0, 1'b1, 16'hCAFE);
        host_sel = 1'b1; host_wr = 1'b1; host_ad_in = 16'hBEEF;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        chk(host_ack_n === 1'b1, "R10 busy strobe", host_ack_n, 1'b1);
        finish_busy(0, "R5");
        dm_ref[40] = 16'hCAFE;
        r_addr = 8'd41;
        do_latch(1'b1, 8'd40, 1'b0);
        do_read(0);
        do_read(0);

        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            int unsigned pick = $urandom % 100;
            int unsigned dly  = $urandom % 4;
            if (pick < 12) do_latch(1'($urandom), 8'($urandom), 1'($urandom));
            else if (pick < 55) do_write(16'($urandom), dly);
            else do_read(dly);
        end

        // R11: boot hold released only by a word at program address 0
        do_reset(1'b1);
        chk(cpu_hold === 1'b1, "R11 hold after reset", cpu_hold, 1'b1);
        do_latch(1'b0, 8'd5, 1'b0);
        do_write(16'h0101, 0);
        do_write(16'h0202, 1);
        chk(cpu_hold === 1'b1, "R11 other address", cpu_hold, 1'b1);
        do_latch(1'b1, 8'd0, 1'b0);
        do_write(16'h0303, 0);
        chk(cpu_hold === 1'b1, "R11 data space zero", cpu_hold, 1'b1);
        do_latch(1'b0, 8'd0, 1'b0);
        do_write(16'h0404, 0);
        chk(cpu_hold === 1'b1, "R11 first half only", cpu_hold, 1'b1);
        do_write(16'h0505, 3);
        chk(cpu_hold === 1'b0, "R11 release", cpu_hold, 1'b0);
        do_latch(1'b0, 8'd0, 1'b0);
        do_read(0);
        do_read(0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule